// File: doc/BRIEF.md
# Split Magnitude Trigger Combiner

This block turns one cycle of a logic analyzer's trigger bus into a single match qualifier for the match-count and pre-trigger stages downstream. When split operation is off, the whole bus goes through one masked pattern compare. When split operation is on, the bus is cut into an upper half and a lower half. Each half has its own condition unit. A unit runs either a masked pattern compare or an unsigned magnitude test against one threshold, or against a pair of thresholds for the range tests. Each unit's result can be inverted on its own.

The two unit results are then merged by an AND, OR or XOR gate, and the gate output can be inverted. As an alternative, either half can drive the qualifier alone. Threshold registers are wider than a half, and only their value modulo 2^HALF_W takes part in a comparison.

Samples arrive as a stream. A sample is offered with `in_valid`, and its qualifier appears with `out_valid` one clock later. There is no `ready` signal and no back-pressure: the counting logic downstream takes one qualifier per cycle, so every valid sample is accepted and produces exactly one result. The configuration inputs are sampled in the same cycle as the bus value they apply to.

Top module: `split_trig_combiner`

## Requirements
- R1: While reset is held and after it is released, `out_valid` and `trig_hit` are 0 until a sample has been accepted.
- R2: A sample with `in_valid`=1 yields `out_valid`=1 on the next clock edge, with its `trig_hit`. A cycle with `in_valid`=0 yields `out_valid`=0 and `trig_hit`=0. No sample is ever stalled.
- R3: With `split_en`=0, `trig_hit` is 1 exactly when every bus bit whose `pat_mask` bit is 1 equals the matching `pat_val` bit. All unit, gate and source settings are ignored in this case, and an all-zero mask always hits.
- R4: With `split_en`=1, a unit whose magnitude enable is 0 matches when its half (upper = `trig_bus[BUS_W-1:HALF_W]`, lower = `trig_bus[HALF_W-1:0]`) equals the matching half of `pat_val` on every bit whose `pat_mask` bit is 1.
- R5: In magnitude mode the half is treated as unsigned. Compare codes 0..5 test the half against threshold A: 0 greater, 1 less, 2 greater or equal, 3 less or equal, 4 equal, 5 not equal.
- R6: Compare code 6 hits when A <= value <= B (A is the lower bound, B the upper bound, both inclusive). Code 7 is the exact complement of code 6. When A > B, code 6 never hits.
- R7: A threshold register acts as its value modulo 2^HALF_W. With 8-bit halves, 300 acts as 44 and 256 acts as 0.
- R8: Each unit's invert bit flips that unit's result before it reaches the gate or source selection.
- R9: With source select 0 or 3, the qualifier is the gate of the two unit results (gate code 0 or 3 = AND, 1 = OR, 2 = XOR), XORed with `gate_inv`.
- R10: Source select 1 uses the upper unit alone and 2 uses the lower unit alone. `gate_inv` and the gate code have no effect in these cases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Sample on `trig_bus` is valid this cycle |
| trig_bus | input | BUS_W | Trigger channel levels |
| split_en | input | 1 | 1 = two half-width units, 0 = full-width pattern compare |
| pat_val | input | BUS_W | Pattern bits |
| pat_mask | input | BUS_W | 1 = compare this bit, 0 = don't care |
| up_mag_en | input | 1 | Upper unit: 1 = magnitude mode, 0 = pattern mode |
| up_cmp | input | 3 | Upper unit compare code |
| up_thr_a | input | THR_W | Upper unit threshold A / range lower bound |
| up_thr_b | input | THR_W | Upper unit range upper bound |
| up_inv | input | 1 | Invert upper unit result |
| lo_mag_en | input | 1 | Lower unit: 1 = magnitude mode, 0 = pattern mode |
| lo_cmp | input | 3 | Lower unit compare code |
| lo_thr_a | input | THR_W | Lower unit threshold A / range lower bound |
| lo_thr_b | input | THR_W | Lower unit range upper bound |
| lo_inv | input | 1 | Invert lower unit result |
| gate_sel | input | 2 | Gate code |
| gate_inv | input | 1 | Invert gate output |
| src_sel | input | 2 | Source select |
| out_valid | output | 1 | Qualifier below is valid |
| trig_hit | output | 1 | Combined match qualifier |

## Verification
The bench aims at the edges of each comparison. It drives values equal to the threshold, one above it and one below it, so a design that swapped strict and non-strict compares, or compared as signed, hits on the wrong side. It tests ranges with the value on each bound and with the bounds reversed, which exposes an exclusive bound or an outside test that is not the exact complement of the inside test. It loads threshold values of 256 and above to catch saturation or an off-by-one wrap in place of a modulo. It sets `gate_inv` while one half is selected alone, so a design that still applied the invert fails. It drives an all-zero mask with split off, which must always hit. It also sends bubbles, so a design that left a stale qualifier high would be caught.

// File: rtl/sptrig_pkg.sv
package sptrig_pkg;
  typedef enum logic [2:0] {
    CMP_GT  = 3'd0,
    CMP_LT  = 3'd1,
    CMP_GE  = 3'd2,
    CMP_LE  = 3'd3,
    CMP_EQ  = 3'd4,
    CMP_NE  = 3'd5,
    CMP_IN  = 3'd6,
    CMP_OUT = 3'd7
  } cmp_e;

  typedef enum logic [1:0] {
    GATE_AND  = 2'd0,
    GATE_OR   = 2'd1,
    GATE_XOR  = 2'd2,
    GATE_AND3 = 2'd3
  } gate_e;

  typedef enum logic [1:0] {
    SRC_GATE  = 2'd0,
    SRC_UPPER = 2'd1,
    SRC_LOWER = 2'd2,
    SRC_GATE3 = 2'd3
  } src_e;
endpackage

// File: rtl/sptrig_cond_unit.sv
module sptrig_cond_unit
  import sptrig_pkg::*;
#(
  parameter int W     = 8,
  parameter int THR_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [W-1:0]     value,
  input  logic [W-1:0]     pat,
  input  logic [W-1:0]     mask,
  input  logic             mag_en,
  input  logic [2:0]       cmp,
  input  logic [THR_W-1:0] thr_a,
  input  logic [THR_W-1:0] thr_b,
  input  logic             inv,
  output logic             hit
);
  // THR_W must exceed W: thresholds are reduced modulo 2^W
  localparam logic [THR_W-1:0] WRAP_MSK = (THR_W'(1) << W) - THR_W'(1);

  logic [THR_W-1:0] vz, a_w, b_w;
  logic pat_hit, mag_hit, in_rng;

  always_comb begin
    vz      = THR_W'(value);
    a_w     = thr_a & WRAP_MSK;
    b_w     = thr_b & WRAP_MSK;
    pat_hit = ((value ^ pat) & mask) == '0;
    in_rng  = (vz >= a_w) && (vz <= b_w);
    unique case (cmp_e'(cmp))
      CMP_GT:  mag_hit = vz >  a_w;
      CMP_LT:  mag_hit = vz <  a_w;
      CMP_GE:  mag_hit = vz >= a_w;
      CMP_LE:  mag_hit = vz <= a_w;
      CMP_EQ:  mag_hit = vz == a_w;
      CMP_NE:  mag_hit = vz != a_w;
      CMP_IN:  mag_hit = in_rng;
      default: mag_hit = !in_rng;
    endcase
    hit = (mag_en ? mag_hit : pat_hit) ^ inv;
  end

  // R5
  eq_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mag_en && cmp == 3'd4 && !inv && hit) |-> (value == thr_a[W-1:0]));

  // R6
  range_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mag_en && cmp == 3'd6 && !inv && hit) |-> (value >= thr_a[W-1:0] && value <= thr_b[W-1:0]));
endmodule

// File: rtl/sptrig_combiner.sv
module sptrig_combiner
  import sptrig_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       up_hit,
  input  logic       lo_hit,
  input  logic [1:0] gate_sel,
  input  logic       gate_inv,
  input  logic [1:0] src_sel,
  output logic       comb_hit
);
  logic gated;

  always_comb begin
    unique case (gate_e'(gate_sel))
      GATE_OR:  gated = up_hit | lo_hit;
      GATE_XOR: gated = up_hit ^ lo_hit;
      default:  gated = up_hit & lo_hit;
    endcase
    unique case (src_e'(src_sel))
      SRC_UPPER: comb_hit = up_hit;
      SRC_LOWER: comb_hit = lo_hit;
      default:   comb_hit = gated ^ gate_inv;
    endcase
  end

  // R9
  and_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (src_sel == 2'd0 && gate_sel == 2'd0 && !gate_inv && comb_hit) |-> (up_hit && lo_hit));

  // R10
  upper_alone_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (src_sel == 2'd1) |-> (comb_hit == up_hit));
endmodule

// File: rtl/split_trig_combiner.sv
module split_trig_combiner #(
  parameter int BUS_W = 16,
  parameter int THR_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [BUS_W-1:0] trig_bus,
  input  logic             split_en,
  input  logic [BUS_W-1:0] pat_val,
  input  logic [BUS_W-1:0] pat_mask,
  input  logic             up_mag_en,
  input  logic [2:0]       up_cmp,
  input  logic [THR_W-1:0] up_thr_a,
  input  logic [THR_W-1:0] up_thr_b,
  input  logic             up_inv,
  input  logic             lo_mag_en,
  input  logic [2:0]       lo_cmp,
  input  logic [THR_W-1:0] lo_thr_a,
  input  logic [THR_W-1:0] lo_thr_b,
  input  logic             lo_inv,
  input  logic [1:0]       gate_sel,
  input  logic             gate_inv,
  input  logic [1:0]       src_sel,
  output logic             out_valid,
  output logic             trig_hit
);
  localparam int HALF_W = BUS_W / 2;
  localparam int NHALF  = 2;

  logic [NHALF-1:0]             h_mag, h_inv, h_hit;
  logic [NHALF-1:0][2:0]        h_cmp;
  logic [NHALF-1:0][THR_W-1:0]  h_ta, h_tb;

  assign h_mag = {up_mag_en, lo_mag_en};
  assign h_inv = {up_inv, lo_inv};
  assign h_cmp = {up_cmp, lo_cmp};
  assign h_ta  = {up_thr_a, lo_thr_a};
  assign h_tb  = {up_thr_b, lo_thr_b};

  for (genvar h = 0; h < NHALF; h++) begin : g_half
    sptrig_cond_unit #(.W(HALF_W), .THR_W(THR_W)) u_cond (
      .clk    (clk),
      .rst_n  (rst_n),
      .value  (trig_bus[h*HALF_W +: HALF_W]),
      .pat    (pat_val[h*HALF_W +: HALF_W]),
      .mask   (pat_mask[h*HALF_W +: HALF_W]),
      .mag_en (h_mag[h]),
      .cmp    (h_cmp[h]),
      .thr_a  (h_ta[h]),
      .thr_b  (h_tb[h]),
      .inv    (h_inv[h]),
      .hit    (h_hit[h])
    );
  end

  logic split_hit, full_hit, next_hit;

  sptrig_combiner u_comb (
    .clk      (clk),
    .rst_n    (rst_n),
    .up_hit   (h_hit[1]),
    .lo_hit   (h_hit[0]),
    .gate_sel (gate_sel),
    .gate_inv (gate_inv),
    .src_sel  (src_sel),
    .comb_hit (split_hit)
  );

  always_comb begin
    full_hit = ((trig_bus ^ pat_val) & pat_mask) == '0;
    next_hit = in_valid & (split_en ? split_hit : full_hit);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      trig_hit  <= 1'b0;
    end else begin
      out_valid <= in_valid;
      trig_hit  <= next_hit;
    end
  end

  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  // R2
  bubble_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && !trig_hit));

  // R1
  hit_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig_hit |-> out_valid);

  // R3
  full_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !split_en && pat_mask == '0) |=> trig_hit);
endmodule

// File: tb/split_trig_combiner_test.sv
`timescale 1ns/1ps
module split_trig_combiner_test;
  localparam int BW = 16;
  localparam int HW = 8;
  localparam int TW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [BW-1:0] trig_bus = '0, pat_val = '0, pat_mask = '0;
  logic split_en = 1'b0;
  logic up_mag_en = 1'b0, lo_mag_en = 1'b0, up_inv = 1'b0, lo_inv = 1'b0, gate_inv = 1'b0;
  logic [2:0] up_cmp = '0, lo_cmp = '0;
  logic [TW-1:0] up_thr_a = '0, up_thr_b = '0, lo_thr_a = '0, lo_thr_b = '0;
  logic [1:0] gate_sel = '0, src_sel = '0;
  logic out_valid, trig_hit;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  split_trig_combiner #(.BUS_W(BW), .THR_W(TW)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .trig_bus(trig_bus),
    .split_en(split_en), .pat_val(pat_val), .pat_mask(pat_mask),
    .up_mag_en(up_mag_en), .up_cmp(up_cmp), .up_thr_a(up_thr_a), .up_thr_b(up_thr_b), .up_inv(up_inv),
    .lo_mag_en(lo_mag_en), .lo_cmp(lo_cmp), .lo_thr_a(lo_thr_a), .lo_thr_b(lo_thr_b), .lo_inv(lo_inv),
    .gate_sel(gate_sel), .gate_inv(gate_inv), .src_sel(src_sel),
    .out_valid(out_valid), .trig_hit(trig_hit)
  );

  function automatic bit unit_model(logic [HW-1:0] v, logic [HW-1:0] p, logic [HW-1:0] m,
                                    logic mg, logic [2:0] c, logic [TW-1:0] ta, logic [TW-1:0] tb);
    int unsigned a, b, x;
    bit r;
    if (!mg) return ((v ^ p) & m) == '0;
    a = ta % 256;
    b = tb % 256;
    x = v;
    case (c)
      3'd0: r = x > a;
      3'd1: r = x < a;
      3'd2: r = x >= a;
      3'd3: r = x <= a;
      3'd4: r = x == a;
      3'd5: r = x != a;
      3'd6: r = (x >= a) && (x <= b);
      default: r = !((x >= a) && (x <= b));
    endcase
    return r;
  endfunction

  function automatic bit exp_hit();
    bit u, l, g;
    if (!split_en) return ((trig_bus ^ pat_val) & pat_mask) == '0;
    u = unit_model(trig_bus[BW-1:HW], pat_val[BW-1:HW], pat_mask[BW-1:HW],
                   up_mag_en, up_cmp, up_thr_a, up_thr_b) ^ up_inv;
    l = unit_model(trig_bus[HW-1:0], pat_val[HW-1:0], pat_mask[HW-1:0],
                   lo_mag_en, lo_cmp, lo_thr_a, lo_thr_b) ^ lo_inv;
    if (src_sel == 2'd1) return u;
    if (src_sel == 2'd2) return l;
    case (gate_sel)
      2'd1: g = u | l;
      2'd2: g = u ^ l;
      default: g = u & l;
    endcase
    return g ^ gate_inv;
  endfunction

  task automatic check(string rq, logic [1:0] act, logic [1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: {out_valid,trig_hit} actual=%b expected=%b", rq, act, exp);
    end
  endtask

  // call at a falling edge with the inputs set; checks at the next falling edge
  task automatic step(string rq);
    bit e;
    in_valid = 1'b1;
    e = exp_hit();
    @(negedge clk);
    check(rq, {out_valid, trig_hit}, {1'b1, e});
  endtask

  task automatic split_mag(logic [2:0] c, int unsigned a, int unsigned b, logic [7:0] v);
    split_en = 1'b1; src_sel = 2'd2; lo_mag_en = 1'b1; lo_inv = 1'b0; gate_inv = 1'b0;
    lo_cmp = c; lo_thr_a = a; lo_thr_b = b; trig_bus = {8'h00, v};
  endtask

  initial begin
    int seed;
    seed = 7;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    // R1
    check("R1", {out_valid, trig_hit}, 2'b00);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", {out_valid, trig_hit}, 2'b00);

    // R3 all-zero mask, split off, unit settings irrelevant
    trig_bus = 16'hBEEF; pat_mask = '0; up_mag_en = 1'b1; up_inv = 1'b1; gate_inv = 1'b1;
    step("R3");
    pat_val = 16'h12F4; pat_mask = 16'hFF0F; trig_bus = 16'h12A4; step("R3");
    trig_bus = 16'h13A4; step("R3");

    // R2 bubble
    in_valid = 1'b0;
    @(negedge clk);
    check("R2", {out_valid, trig_hit}, 2'b00);

    // R4 split bit mode, upper alone
    split_en = 1'b1; up_mag_en = 1'b0; up_inv = 1'b0; src_sel = 2'd1;
    pat_val = 16'hA500; pat_mask = 16'hF000; trig_bus = 16'hA7FF; step("R4");
    trig_bus = 16'h97FF; step("R4");

    // R5 boundary compares on the lower half
    for (int c = 0; c < 6; c++) begin
      split_mag(3'(c), 100, 0, 8'd99);  step("R5");
      split_mag(3'(c), 100, 0, 8'd100); step("R5");
      split_mag(3'(c), 100, 0, 8'd101); step("R5");
    end
    split_mag(3'd0, 100, 0, 8'd200); step("R5"); // unsigned: 200 > 100

    // R6 inclusive bounds, complement, reversed bounds
    split_mag(3'd6, 10, 20, 8'd10); step("R6");
    split_mag(3'd6, 10, 20, 8'd20); step("R6");
    split_mag(3'd6, 10, 20, 8'd21); step("R6");
    split_mag(3'd7, 10, 20, 8'd9);  step("R6");
    split_mag(3'd7, 10, 20, 8'd20); step("R6");
    split_mag(3'd6, 30, 20, 8'd25); step("R6");
    split_mag(3'd7, 30, 20, 8'd25); step("R6");

    // R7 wrap
    split_mag(3'd4, 300, 0, 8'd44); step("R7");
    split_mag(3'd4, 256, 0, 8'd0);  step("R7");
    split_mag(3'd6, 266, 276, 8'd15); step("R7");

    // R8 unit invert
    split_mag(3'd4, 5, 0, 8'd5); lo_inv = 1'b1; step("R8");

    // R10 gate_inv ignored when one half stands alone
    split_mag(3'd4, 5, 0, 8'd5); gate_inv = 1'b1; gate_sel = 2'd2; step("R10");
    src_sel = 2'd1; up_mag_en = 1'b1; up_cmp = 3'd4; up_thr_a = 3; up_inv = 1'b0;
    trig_bus = 16'h0300; step("R10");

    // R9 every gate with inverts
    for (int g = 0; g < 4; g++) begin
      for (int k = 0; k < 4; k++) begin
        split_en = 1'b1; src_sel = (k == 3) ? 2'd3 : 2'd0; gate_sel = 2'(g); gate_inv = k[0];
        up_mag_en = 1'b1; lo_mag_en = 1'b1; up_cmp = 3'd4; lo_cmp = 3'd4;
        up_thr_a = 7; lo_thr_a = 9; up_inv = 1'b0; lo_inv = 1'b0;
        trig_bus = {k[1] ? 8'd7 : 8'd6, k[0] ? 8'd9 : 8'd1};
        step("R9");
      end
    end

    // random mix, R2..R10
    for (int i = 0; i < 400; i++) begin
      split_en = ($urandom % 4) != 0;
      trig_bus = 16'($urandom); pat_val = 16'($urandom);
      pat_mask = ($urandom % 4 == 0) ? 16'h0 : 16'($urandom);
      up_mag_en = 1'($urandom); lo_mag_en = 1'($urandom);
      up_cmp = 3'($urandom); lo_cmp = 3'($urandom);
      up_thr_a = $urandom % 512; up_thr_b = $urandom % 512;
      lo_thr_a = $urandom % 512; lo_thr_b = $urandom % 512;
      if ($urandom % 3 == 0) lo_thr_a = {24'h0, trig_bus[7:0]} + 32'(256 * ($urandom % 3));
      up_inv = 1'($urandom); lo_inv = 1'($urandom); gate_inv = 1'($urandom);
      gate_sel = 2'($urandom); src_sel = 2'($urandom);
      if ($urandom % 5 == 0) begin
        in_valid = 1'b0;
        @(negedge clk);
        check("R2", {out_valid, trig_hit}, 2'b00);
      end else begin
        step("R9");
      end
    end

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule